// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host side of a three-wire link to an 8-bit sampling converter. The wires are an active-low chip select, a serial clock and a single data line that both ends share. When the block is idle and sees a request, it lowers chip select and runs one frame. In the configured mode it first drives a start bit and a 3-bit setup word onto the data line. It then lets go of the line so that the converter can answer. The converter's first bit is a null bit, which the block throws away. Next come eight result bits, most significant first. The converter then sends seven of those bits again in the reverse order, and the block uses this second copy to check the first. At the end of the frame the block raises chip select and pulses a done strobe. The captured sample and a mismatch flag are held until the next done strobe.

In the second mode the block sends nothing. The first clock pulse of the frame only wakes the converter's output, and the null bit and the data follow as in the configured mode. The serial clock comes from the system clock: each half period lasts a parameter number of system cycles. The data pin is split into an output value, an output enable and an input, and the tri-state pad sits outside the block.

Top module: `sadc_host`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, sd_oe_o is 0, done_o is 0, sample_o is 0 and mismatch_o is 0.
- R2: A start_i seen while idle lowers cs_n_o on the next cycle. Each bit period is HALF_DIV cycles with sclk_o low and then HALF_DIV cycles with sclk_o high. sclk_o is 0 whenever cs_n_o is 1.
- R3: When nocfg_i is 0 at the request, the frame has 20 bit periods. In periods 0 to 3 the block drives sd_o with 1, then cfg_i[2], cfg_i[1] and cfg_i[0]. Each bit is set at the start of its low half and held through the rising edge.
- R4: sd_oe_o is high only while cs_n_o is low. It falls one system cycle after the rising edge of the last setup bit, and it is not high during the null bit or the result bits.
- R5: When nocfg_i is 1 at the request, the frame has 17 bit periods. The first period is a bare enabling pulse, and sd_oe_o stays 0 for the whole frame.
- R6: The bit sampled at the rising edge of the period just after the lead periods (the null bit) has no effect on sample_o or mismatch_o.
- R7: The bits sampled at the rising edges of the next 8 periods form sample_o, with the first of them as bit 7.
- R8: The last 7 periods carry result bits 1 through 7, lowest first. mismatch_o is 1 if any of these differs from the same bit of the captured sample. Bit 0 is never compared.
- R9: After the high half of the final period, cs_n_o rises and sclk_o falls in the same cycle. done_o is then high for exactly that one cycle. sample_o and mismatch_o take their new values in that cycle and do not change until the next done_o.
- R10: A start_i that arrives while a frame is running has no effect on that frame's timing, mode, setup bits or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame |
| nocfg_i | input | 1 | 1 selects the mode without a setup word |
| cfg_i | input | 3 | Setup word sent in the configured mode |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Data line value when driven |
| sd_oe_o | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line as seen at the pad |
| sample_o | output | 8 | Last captured sample |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| mismatch_o | output | 1 | Repeated bits disagreed with the sample |

## Verification
A converter model in the bench runs frames in both modes, with several setup words and several sample values. Alternating and all-ones values show whether the shift order is right and whether the bits reach the right positions. A flipped null bit shows that the discard slot really has no effect. A flipped bit in the repeated copy shows that the mismatch detector works. A flipped primary bit 0 and a flipped primary bit 7 mark the two ends of the comparison range: one must leave the flag clear and the other must set it. Requests sent in the middle of a frame, with the opposite mode and setup word, show whether the running frame is protected from them.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    parameter int RES_W = 8;
    parameter int CFG_W = 3;

    localparam int MAX_SLOTS = 1 + CFG_W + 2 * RES_W;
    localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);
    localparam int BIDX_W    = $clog2(RES_W);

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } half_e;

    typedef struct packed {
        logic             use_cfg;
        logic [CFG_W-1:0] cfg;
    } xfer_t;

    // number of bit periods before the null bit
    function automatic slot_t lead_slots(input logic use_cfg);
        return use_cfg ? slot_t'(1 + CFG_W) : slot_t'(1);
    endfunction

    // index of the final bit period of a frame
    function automatic slot_t last_slot(input logic use_cfg);
        return lead_slots(use_cfg) + slot_t'(2 * RES_W - 1);
    endfunction

    // value driven in a lead period: start bit, then setup word MSB first
    function automatic logic lead_bit(input slot_t s, input logic [CFG_W-1:0] cfg);
        logic b;
        b = 1'b0;
        if (s == '0) begin
            b = 1'b1;
        end else begin
            for (int k = 1; k <= CFG_W; k++) begin
                if (s == slot_t'(k)) b = cfg[CFG_W-k];
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/sadc_halfgen.sv
module sadc_halfgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    // a half period always spans counted cycles of an active frame
    p_tick_after_run_r2: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(run));

endmodule

// File: rtl/sadc_rxpath.sv
module sadc_rxpath
    import sadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             smp_en,
    input  slot_t            slot,
    input  slot_t            lead,
    input  logic             din,
    output logic [RES_W-1:0] word,
    output logic             bad
);
    logic [RES_W-1:0] shreg;
    logic             bad_q;
    slot_t            rel;
    logic [BIDX_W-1:0] ridx;
    logic             in_frame, is_main, is_echo;

    always_comb begin
        in_frame = (slot >= lead);
        rel      = slot - lead;
        is_main  = in_frame && (rel >= slot_t'(1)) && (rel <= slot_t'(RES_W));
        is_echo  = in_frame && (rel > slot_t'(RES_W)) && (rel <= slot_t'(2 * RES_W - 1));
        ridx     = BIDX_W'(rel - slot_t'(RES_W));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg <= '0;
            bad_q <= 1'b0;
        end else if (smp_en) begin
            if (is_main) begin
                shreg <= {shreg[RES_W-2:0], din};
            end else if (is_echo && (din != shreg[ridx])) begin
                bad_q <= 1'b1;
            end
        end
    end

    assign word = shreg;
    assign bad  = bad_q;

    p_hold_between_samples_r7: assert property (@(posedge clk) disable iff (rst)
        (!smp_en && !clear) |=> $stable(shreg));

    p_null_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_en && !clear && slot == lead) |=> ($stable(shreg) && $stable(bad_q)));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (bad_q && !clear) |=> bad_q);

endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             nocfg_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sd_o,
    output logic             sd_oe_o,
    input  logic             sd_i,
    output logic [RES_W-1:0] sample_o,
    output logic             done_o,
    output logic             mismatch_o
);
    logic             busy_q;
    xfer_t            req_q;
    slot_t            slot_q;
    half_e            ph_q;
    logic             cs_n_q, sclk_q, oe_q, sdo_q, done_q, rise_d;
    logic [RES_W-1:0] sample_q;
    logic             mis_q;

    logic             tick, accept, smp_en;
    logic [RES_W-1:0] rx_word;
    logic             rx_bad;
    slot_t            lead;

    assign accept = !busy_q && start_i;
    assign smp_en = busy_q && tick && (ph_q == PH_LOW);
    assign lead   = lead_slots(req_q.use_cfg);

    sadc_halfgen #(.HALF_DIV(HALF_DIV)) u_halfgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q),
        .tick (tick)
    );

    sadc_rxpath u_rxpath (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .smp_en (smp_en),
        .slot   (slot_q),
        .lead   (lead),
        .din    (sd_i),
        .word   (rx_word),
        .bad    (rx_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            req_q    <= '0;
            slot_q   <= '0;
            ph_q     <= PH_LOW;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b0;
            oe_q     <= 1'b0;
            sdo_q    <= 1'b0;
            done_q   <= 1'b0;
            rise_d   <= 1'b0;
            sample_q <= '0;
            mis_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rise_d <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q        <= 1'b1;
                    req_q.use_cfg <= !nocfg_i;
                    req_q.cfg     <= cfg_i;
                    slot_q        <= '0;
                    ph_q          <= PH_LOW;
                    cs_n_q        <= 1'b0;
                    sclk_q        <= 1'b0;
                    oe_q          <= !nocfg_i;
                    sdo_q         <= !nocfg_i;
                end
            end else begin
                if (tick) begin
                    if (ph_q == PH_LOW) begin
                        ph_q   <= PH_HIGH;
                        sclk_q <= 1'b1;
                        rise_d <= 1'b1;
                    end else if (slot_q == last_slot(req_q.use_cfg)) begin
                        busy_q   <= 1'b0;
                        cs_n_q   <= 1'b1;
                        sclk_q   <= 1'b0;
                        oe_q     <= 1'b0;
                        done_q   <= 1'b1;
                        sample_q <= rx_word;
                        mis_q    <= rx_bad;
                    end else begin
                        ph_q   <= PH_LOW;
                        sclk_q <= 1'b0;
                        slot_q <= slot_q + 1'b1;
                        sdo_q  <= lead_bit(slot_q + 1'b1, req_q.cfg);
                    end
                end
                // turn the line around right after the last setup bit is taken
                if (rise_d && (slot_q == lead - 1'b1)) begin
                    oe_q <= 1'b0;
                end
            end
        end
    end

    assign cs_n_o     = cs_n_q;
    assign sclk_o     = sclk_q;
    assign sd_o       = sdo_q;
    assign sd_oe_o    = oe_q;
    assign sample_o   = sample_q;
    assign done_o     = done_q;
    assign mismatch_o = mis_q;

    p_quiet_clock_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    p_drive_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        sd_oe_o |-> !cs_n_o);

    p_release_after_rise_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(sd_oe_o) && !cs_n_o) |-> (sclk_o && $past(sclk_o)));

    p_no_drive_bare_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !req_q.use_cfg) |-> !sd_oe_o);

    p_start_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (sd_oe_o && slot_q == '0) |-> sd_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_closes_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(cs_n_o));

    p_result_held_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(sample_o) && $stable(mismatch_o)));

    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && start_i) |=> $stable(req_q));

endmodule

// File: tb/sadc_host_bench.sv
module sadc_host_bench;
    import sadc_pkg::*;

    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       nocfg_i = 1'b0;
    logic [2:0] cfg_i = 3'b000;
    logic       cs_n_o, sclk_o, sd_o, sd_oe_o, sd_i;
    logic [7:0] sample_o;
    logic       done_o, mismatch_o;

    always #5 clk = ~clk;

    // converter model drive, pull-up when nobody drives
    logic dev_en = 1'b0;
    logic dev_bit = 1'b0;
    assign sd_i = sd_oe_o ? sd_o : (dev_en ? dev_bit : 1'b1);

    sadc_host #(.HALF_DIV(H)) u_sadc_host (
        .clk(clk), .rst(rst), .start_i(start_i), .nocfg_i(nocfg_i), .cfg_i(cfg_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i),
        .sample_o(sample_o), .done_o(done_o), .mismatch_o(mismatch_o)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // frame under test, as the converter model sees it
    bit       cur_nocfg = 1'b0;
    bit [2:0] cur_cfg = 3'b000;
    bit [7:0] cur_val = 8'h00;
    int       cur_fault = 0;   // 0 none, 1 null flipped, 2 echo bit flipped, 3 main bit flipped
    int       cur_j = 0;
    bit [7:0] fr_sample = 8'h00;
    bit       fr_mis = 1'b0;
    bit [7:0] hold_sample = 8'h00;
    bit       hold_mis = 1'b0;

    function automatic bit dev_out(input int q);
        bit b;
        b = 1'b0;
        if (q == 0) begin
            b = (cur_fault == 1);
        end else if (q <= 8) begin
            b = cur_val[8-q];
            if (cur_fault == 3 && cur_j == 8 - q) b = !b;
        end else if (q <= 15) begin
            b = cur_val[q-8];
            if (cur_fault == 2 && cur_j == q - 8) b = !b;
        end
        return b;
    endfunction

    // reference model of the host timing
    logic m_active = 1'b0;
    int   m_t = 0;
    logic m_cfg = 1'b0;
    logic [2:0] m_cfgw = 3'b000;

    function automatic int frame_cycles(input logic use_cfg);
        return ((use_cfg ? 4 : 1) + 16) * 2 * H;
    endfunction

    wire m_busy = m_active && (m_t < frame_cycles(m_cfg));

    always @(posedge clk) begin
        if (rst) begin
            m_active <= 1'b0;
            m_t      <= 0;
        end else begin
            if (m_active) begin
                if (m_t == frame_cycles(m_cfg)) m_active <= 1'b0;
                else m_t <= m_t + 1;
            end
            if (!m_busy && start_i) begin
                m_active <= 1'b1;
                m_t      <= 0;
                m_cfg    <= !nocfg_i;
                m_cfgw   <= cfg_i;
            end
        end
    end

    // per-cycle comparison and converter model, away from the active edge
    logic prev_sclk = 1'b0;
    int   rcount = 0;
    bit [3:0] captured = 4'b0;

    always @(negedge clk) begin
        if (!rst) begin
            int  slot, w;
            bit  e_cs, e_sclk, e_oe, e_sd, e_done;
            bit [7:0] e_s;
            bit  e_m;
            e_sd = 1'b0;
            if (m_busy) begin
                slot   = m_t / (2 * H);
                w      = m_t % (2 * H);
                e_cs   = 1'b0;
                e_sclk = (w >= H);
                e_oe   = m_cfg && (slot < 3 || (slot == 3 && w <= H));
                e_sd   = (slot == 0) ? 1'b1 : m_cfgw[3-slot];
                e_done = 1'b0;
            end else begin
                e_cs   = 1'b1;
                e_sclk = 1'b0;
                e_oe   = 1'b0;
                e_done = m_active;
            end
            e_s = e_done ? fr_sample : hold_sample;
            e_m = e_done ? fr_mis : hold_mis;
            chk("R2 chip select", cs_n_o, e_cs);
            chk("R2 serial clock", sclk_o, e_sclk);
            chk(m_cfg ? "R4 line enable" : "R5 line enable", sd_oe_o, e_oe);
            if (e_oe) chk("R3 driven bit", sd_o, e_sd);
            chk("R9 done strobe", done_o, e_done);
            chk("R7 sample value", sample_o, e_s);
            chk("R8 mismatch flag", mismatch_o, e_m);
            if (sd_oe_o && dev_en) chk("R4 line contention", 1, 0);
            if (e_done) begin
                hold_sample = fr_sample;
                hold_mis    = fr_mis;
            end

            // converter model
            if (cs_n_o) begin
                rcount = 0;
                dev_en = 1'b0;
            end else if (sclk_o && !prev_sclk) begin
                if (!cur_nocfg && rcount < 4) begin
                    captured[3-rcount] = sd_i;
                    if (rcount == 3) chk("R3 start and setup seen by converter", captured, {1'b1, cur_cfg});
                end
                rcount++;
            end else if (!sclk_o && prev_sclk) begin
                if (rcount >= (cur_nocfg ? 1 : 4)) begin
                    dev_en  = 1'b1;
                    dev_bit = dev_out(rcount - (cur_nocfg ? 1 : 4));
                end
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic run_frame(input bit nocfg, input bit [2:0] cfg, input bit [7:0] val,
                             input int fault, input int j, input bit poke);
        int guard;
        @(negedge clk);
        cur_nocfg = nocfg;
        cur_cfg   = cfg;
        cur_val   = val;
        cur_fault = fault;
        cur_j     = j;
        fr_sample = (fault == 3) ? (val ^ (8'h01 << j)) : val;
        fr_mis    = (fault == 2 && j >= 1) || (fault == 3 && j >= 1);
        start_i = 1'b1;
        nocfg_i = nocfg;
        cfg_i   = cfg;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R10: conflicting request in mid-frame
            repeat (25) @(negedge clk);
            start_i = 1'b1;
            nocfg_i = !nocfg;
            cfg_i   = ~cfg;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (!done_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 1000) chk("R9 frame end reached", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk("R1 cs idle", cs_n_o, 1);
        chk("R1 sclk idle", sclk_o, 0);
        chk("R1 enable idle", sd_oe_o, 0);
        chk("R1 done idle", done_o, 0);
        chk("R1 sample idle", sample_o, 0);
        chk("R1 mismatch idle", mismatch_o, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_frame(1'b0, 3'b101, 8'hA5, 0, 0, 1'b0);   // R3 R7 clean frame
        run_frame(1'b1, 3'b000, 8'h3C, 0, 0, 1'b0);   // R5 bare frame
        run_frame(1'b0, 3'b010, 8'h81, 2, 4, 1'b0);   // R8 echo error
        run_frame(1'b0, 3'b111, 8'h5A, 1, 0, 1'b0);   // R6 null flipped
        run_frame(1'b1, 3'b000, 8'hF0, 3, 0, 1'b0);   // R8 bit 0 not compared
        run_frame(1'b0, 3'b000, 8'h00, 3, 7, 1'b0);   // R8 bit 7 compared
        run_frame(1'b0, 3'b110, 8'hFF, 0, 0, 1'b1);   // R10 ignored request
        run_frame(1'b1, 3'b011, 8'h01, 2, 7, 1'b1);   // R10 ignored request, bare mode
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule